// File: doc/BRIEF.md
# Chainable Up/Down Binary Counter

This block is a synchronous binary counter built from identical 4-bit slices. On each rising clock edge it loads a parallel word, steps by one in a chosen direction, or keeps its value. A load request, which is active low, overrides everything else. Stepping needs two active-low enables at the same time. One of them, the slice enable, is shared by every slice. The other, the carry enable, also qualifies the terminal-count output.

Slices are chained. The terminal-count output of each slice drives the carry enable of the next slice. All slices share the clock, direction, load and slice enable. The full-width value therefore behaves as one wide counter. The terminal-count output of the last slice tells an outer stage that the whole chain is about to roll over.

The count has no reset. It takes a defined value only after the first load, and users must load before they rely on the count.

Top module: `updown_chain`

## Requirements
- R1: The count changes only at a rising clock edge. Between edges it stays constant while any input changes.
- R2: When `load_n` is 0 at an edge, `din` is copied into the count, whatever the values of `slice_en_n` and `carry_en_n`.
- R3: The count steps only when `load_n` is 1 and both `slice_en_n` and `carry_en_n` are 0 at the edge.
- R4: When it steps, the count goes up by one if `dir_up` is 1 and down by one if `dir_up` is 0. In both directions it wraps modulo 2^(4*STAGES).
- R5: When `load_n` is 1 and either `slice_en_n` or `carry_en_n` is 1, the count keeps its value.
- R6: `tc_n` is 0 exactly when `carry_en_n` is 0 and the full count is at its terminal value. The terminal value is all ones when `dir_up` is 1 and all zeros when `dir_up` is 0.
- R7: `tc_n` is combinational. A change of `dir_up` or `carry_en_n` changes it without a clock edge.
- R8: Slice k+1 (bits 4k+7:4k+4) steps only in cycles where slices 0..k are all at their terminal value. This carries and borrows correctly across slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low synchronous parallel load |
| slice_en_n | input | 1 | Active-low step enable, shared by all slices |
| carry_en_n | input | 1 | Active-low step enable into slice 0; also gates `tc_n` |
| dir_up | input | 1 | 1 = increment, 0 = decrement |
| din | input | 4*STAGES | Parallel load word |
| count | output | 4*STAGES | Current count |
| tc_n | output | 1 | Active-low terminal count of the last slice |

## Verification
A load and a step can be requested in the same cycle. The bench provokes this by driving `load_n` low while both enables are low, in both directions, from start values at and away from the terminal value. The expected result is the loaded word, never the stepped value.

Terminal count and stepping also meet in one cycle. At the wrap edge the bench checks `tc_n` just before the clock and the count after it. This is done across slice boundaries going up (…FF to 00) and going down (00 to …FF).

// File: rtl/updown_pkg.sv
package updown_pkg;
    localparam int SLICE_BITS = 4;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } slice_op_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import updown_pkg::*;
(
    input  logic      load_n,
    input  logic      slice_en_n,
    input  logic      carry_en_n,
    output slice_op_e op
);
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (!slice_en_n && !carry_en_n)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
    parameter int BITS = 4
) (
    input  logic [BITS-1:0] cnt,
    input  logic            dir_up,
    input  logic            carry_en_n,
    output logic            tc_n
);
    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &cnt;
        at_bottom = ~|cnt;
        tc_n      = ~(~carry_en_n & (dir_up ? at_top : at_bottom));
    end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import updown_pkg::*;
#(
    parameter int BITS = SLICE_BITS
) (
    input  logic            clk,
    input  logic            load_n,
    input  logic            slice_en_n,
    input  logic            carry_en_n,
    input  logic            dir_up,
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] cnt,
    output logic            tc_n
);
    localparam logic [BITS-1:0] ONE = BITS'(1);

    typedef struct packed {
        logic [BITS-1:0] cnt;
    } slice_t;

    slice_t    s_d, s_q;
    slice_op_e op;

    cnt_mode_sel u_mode (
        .load_n     (load_n),
        .slice_en_n (slice_en_n),
        .carry_en_n (carry_en_n),
        .op         (op)
    );

    always_comb begin
        s_d = s_q;
        case (op)
            OP_LOAD: s_d.cnt = din;
            OP_STEP: s_d.cnt = dir_up ? s_q.cnt + ONE : s_q.cnt - ONE;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    cnt_term_detect #(.BITS(BITS)) u_term (
        .cnt        (s_q.cnt),
        .dir_up     (dir_up),
        .carry_en_n (carry_en_n),
        .tc_n       (tc_n)
    );

    // Count is undefined until the first load; checks start after it.
    logic seen_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!load_n) seen_q <= 1'b1;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!seen_q)
        !load_n |=> cnt == $past(din));

    p_hold_r5: assert property (@(posedge clk) disable iff (!seen_q)
        (load_n && (slice_en_n || carry_en_n)) |=> $stable(cnt));

    p_step_r4: assert property (@(posedge clk) disable iff (!seen_q)
        (load_n && !slice_en_n && !carry_en_n) |=>
            cnt == ($past(dir_up) ? $past(cnt) + ONE : $past(cnt) - ONE));

    p_moves_r3: assert property (@(posedge clk) disable iff (!seen_q)
        (load_n && !slice_en_n && !carry_en_n) |=> !$stable(cnt));
endmodule

// File: rtl/updown_chain.sv
module updown_chain
    import updown_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                           clk,
    input  logic                           load_n,
    input  logic                           slice_en_n,
    input  logic                           carry_en_n,
    input  logic                           dir_up,
    input  logic [SLICE_BITS*STAGES-1:0]   din,
    output logic [SLICE_BITS*STAGES-1:0]   count,
    output logic                           tc_n
);
    localparam int W = SLICE_BITS * STAGES;

    logic [STAGES-1:0] cet_w;
    logic [STAGES-1:0] tc_w;

    for (genvar i = 0; i < STAGES; i++) begin : g_slice
        if (i == 0) begin : g_first
            assign cet_w[i] = carry_en_n;
        end else begin : g_next
            assign cet_w[i] = tc_w[i-1];
        end

        cnt_slice #(.BITS(SLICE_BITS)) u_slice (
            .clk        (clk),
            .load_n     (load_n),
            .slice_en_n (slice_en_n),
            .carry_en_n (cet_w[i]),
            .dir_up     (dir_up),
            .din        (din[i*SLICE_BITS +: SLICE_BITS]),
            .cnt        (count[i*SLICE_BITS +: SLICE_BITS]),
            .tc_n       (tc_w[i])
        );
    end

    assign tc_n = tc_w[STAGES-1];

    logic seen_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!load_n) seen_q <= 1'b1;
    end

    // Chain-level terminal count must reflect the full-width value (R6, R8).
    p_tc_full_r6: assert property (@(posedge clk) disable iff (!seen_q)
        !tc_n |-> (!carry_en_n && (count == (dir_up ? {W{1'b1}} : {W{1'b0}}))));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!seen_q)
        (load_n && !slice_en_n && !carry_en_n && dir_up && (&count)) |=> (count == '0));
endmodule

// File: tb/updown_chain_test.sv
`timescale 1ns/1ps
module updown_chain_test;
    localparam int STAGES = 2;
    localparam int W      = 4 * STAGES;
    localparam int MASK   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         load_n = 1'b1, slice_en_n = 1'b1, carry_en_n = 1'b1, dir_up = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc_n;

    int model = 0;
    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    updown_chain #(.STAGES(STAGES)) uut (
        .clk(clk), .load_n(load_n), .slice_en_n(slice_en_n), .carry_en_n(carry_en_n),
        .dir_up(dir_up), .din(din), .count(count), .tc_n(tc_n)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_tc(input logic ce, input logic up);
        if (!ce && (up ? (model == MASK) : (model == 0))) return 0;
        return 1;
    endfunction

    // Drive at falling edge, check tc and stability before the edge, count after it.
    task automatic apply(input logic ld, input logic cp, input logic ct, input logic up,
                         input int d, input string tag);
        @(negedge clk);
        load_n = ld; slice_en_n = cp; carry_en_n = ct; dir_up = up; din = W'(d);
        #1;
        check("R6", int'(tc_n), exp_tc(ct, up));
        check("R1", int'(count), model);
        @(posedge clk);
        if (!ld) model = d & MASK;
        else if (!cp && !ct) model = (up ? model + 1 : model - 1) & MASK;
        #1;
        check(tag, int'(count), model);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int starts [10] = '{0, 1, 7, 8, 15, 16, 127, 128, 254, 255};
        // First defined state comes from a load (R2)
        apply(1'b0, 1'b1, 1'b1, 1'b1, 0, "R2");

        // Every enable combination, both directions, several start values
        foreach (starts[s]) begin
            for (int c = 0; c < 8; c++) begin
                for (int u = 0; u < 2; u++) begin
                    string tag;
                    apply(1'b0, 1'b1, 1'b1, 1'b1, starts[s], "R2");
                    if (c[2] == 1'b0) tag = "R2";
                    else if (c[1:0] == 2'b00) tag = "R4";
                    else tag = "R5";
                    apply(c[2], c[1], c[0], u[0], (~starts[s]) & MASK, tag);
                    if (c[2] == 1'b1 && c[1:0] == 2'b00)
                        check("R3", int'(count != W'(starts[s])), 1);
                end
            end
        end

        // Long up run across slice boundaries and full wrap (R8)
        apply(1'b0, 1'b1, 1'b1, 1'b1, 240, "R2");
        for (int k = 0; k < 300; k++) apply(1'b1, 1'b0, 1'b0, 1'b1, 0, "R8");
        // Long down run through zero (R8)
        apply(1'b0, 1'b1, 1'b1, 1'b0, 20, "R2");
        for (int k = 0; k < 300; k++) apply(1'b1, 1'b0, 1'b0, 1'b0, 0, "R8");

        // Slice enable toggling while counting up (R3, R5)
        apply(1'b0, 1'b1, 1'b1, 1'b1, 12, "R2");
        for (int k = 0; k < 40; k++) apply(1'b1, k[0], 1'b0, 1'b1, 0, k[0] ? "R5" : "R3");

        // Combinational terminal count (R7)
        apply(1'b0, 1'b1, 1'b1, 1'b1, MASK, "R2");
        @(negedge clk);
        load_n = 1'b1; slice_en_n = 1'b1; carry_en_n = 1'b0; dir_up = 1'b1; #1;
        check("R7", int'(tc_n), 0);
        dir_up = 1'b0; #1;
        check("R7", int'(tc_n), 1);
        dir_up = 1'b1; #1;
        check("R7", int'(tc_n), 0);
        carry_en_n = 1'b1; #1;
        check("R7", int'(tc_n), 1);
        check("R1", int'(count), MASK);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule